// File: doc/BRIEF.md
# Legacy Memory Region Decoder

This block sits between an emulated real-mode CPU bus and the stores that back its 1 MiB physical space. Each request carries a 20-bit address, a direction and a size of one, two or four bytes. The block decodes the start address into a target code and a translated offset. The targets are the option-ROM image, the video frame buffer, main RAM and a small table of constant identity bytes. The stores themselves sit outside the block and use the target code and offset to perform the access.

For the constant table the block supplies the read data itself, packed little-endian across byte lanes. Two fault conditions are reported with flags. One is an access that lands above the programmable ROM limit but still below the end of the ROM window. The other is an address past the configured RAM size. Both are steered to RAM offset 0. An optional mode hides the frame buffer: reads of that window return zero and writes to it are dropped.

The ROM limit, the RAM size and the frame-buffer mode are loaded through a small configuration port while no request is presented. Every request gets a registered response exactly one cycle later.

Top module: `legacy_mem_decoder`

## Requirements
- R1: An address from 0xC0000 up to and including the ROM limit gives target code 1 (ROM) with offset addr - 0xC0000.
- R2: An address from 0xC0000 upward that is above the ROM limit and below 0xD0000 gives target code 3 (RAM), offset 0, and raises rsp_warn_o.
- R3: An address in 0xA0000..0xBFFFF, with frame-buffer hiding off, gives target code 2 (video) with offset addr - 0xA0000.
- R4: An address from 0xFFFF5 to 0xFFFFF gives target code 4 (constant) with offset addr - 0xFFFF5. The bytes at 0xFFFF5..0xFFFFC are the ASCII text "08/14/99" (0x30 0x38 0x2F 0x31 0x34 0x2F 0x39 0x39). 0xFFFFD reads 0x00, 0xFFFFE reads 0xFC and 0xFFFFF reads 0x00. A lane that falls past 0xFFFFF reads 0x00.
- R5: req_size_i selects the width: 0 is byte, 1 is word, and 2 or 3 is dword. For a constant read, the byte at addr+i is placed in rsp_rdata_o bits [8i+7:8i], and unused lanes read 0.
- R6: An address at or above the configured RAM size that no earlier region claims gives target code 3, offset 0, and raises rsp_halt_o.
- R7: Any other address gives target code 3 with offset equal to the address.
- R8: With frame-buffer hiding on, an address in 0xA0000..0xBFFFF gives target code 0, rsp_rdata_o = 0 and rsp_wen_o = 0. Other addresses are unaffected.
- R9: Regions are checked in this priority order: hidden frame buffer, ROM, gap, video, constant table, RAM size, then plain RAM.
- R10: rsp_wen_o is 1 for a write to targets 1, 2 or 3, and 0 for reads and for targets 0 and 4. rsp_rdata_o is 0 on writes.
- R11: A configuration write loads the ROM limit when cfg_sel_i = 0, the RAM size when cfg_sel_i = 1, and the frame-buffer hiding bit (data bit 0) when cfg_sel_i = 2. It is ignored while req_valid_i is high.
- R12: rsp_valid_o follows req_valid_i one cycle later. While rsp_valid_o is low, all other response outputs are 0. After reset, the limit is ROM_LIM_RST, the RAM size is RAM_SIZE_RST and hiding is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration register select |
| cfg_data_i | input | 21 | Configuration write data |
| req_valid_i | input | 1 | Request present |
| req_we_i | input | 1 | Request is a write |
| req_size_i | input | 2 | Access size code |
| req_addr_i | input | 20 | Physical start address |
| rsp_valid_o | output | 1 | Response valid |
| rsp_tgt_o | output | 3 | Target store code |
| rsp_off_o | output | 20 | Offset into the target store |
| rsp_wen_o | output | 1 | Store should commit the write |
| rsp_rdata_o | output | 32 | Constant-table read data, little-endian |
| rsp_halt_o | output | 1 | Address beyond RAM size |
| rsp_warn_o | output | 1 | Address in the gap above the ROM limit |

## Verification
The bench overrides the reset values to ROM_LIM_RST = 0xC7FFF and RAM_SIZE_RST = 0x90000. With these values a gap window 0xC8000..0xCFFFF is open from the start, and addresses 0x90000 and 0xD0000 fall past RAM, so the gap, the halt path and the RAM boundary are all reachable without any configuration. Later it reprograms the RAM size down to 0x10000. The ROM, video, constant and gap regions then overlap the out-of-range space, and the priority order decides every one of those accesses. It also moves the ROM limit so that the gap disappears.

// File: rtl/lmd_pkg.sv
package lmd_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam int NBYTES = DATA_W / 8;
  localparam int SIZE_W = 2;
  localparam int TGT_W  = 3;

  typedef enum logic [TGT_W-1:0] {
    TGT_NONE  = 3'd0,
    TGT_ROM   = 3'd1,
    TGT_VID   = 3'd2,
    TGT_RAM   = 3'd3,
    TGT_CONST = 3'd4
  } tgt_e;

  localparam logic [ADDR_W-1:0] VID_BASE = 20'hA0000;
  localparam logic [ADDR_W-1:0] VID_TOP  = 20'hBFFFF;
  localparam logic [ADDR_W-1:0] ROM_BASE = 20'hC0000;
  localparam logic [ADDR_W-1:0] GAP_END  = 20'hD0000;
  localparam logic [ADDR_W-1:0] ID_BASE  = 20'hFFFF5;
  localparam logic [ADDR_W-1:0] ID_MODEL = 20'hFFFFE;
  localparam int                DATE_LEN = 8;
  localparam logic [8*DATE_LEN-1:0] DATE_TXT = "08/14/99";
  localparam logic [7:0] MODEL_BYTE = 8'hFC;
  localparam logic [7:0] SUBMODEL_BYTE = 8'h00;

  function automatic logic [7:0] ident_byte(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] k;
    int idx;
    k = a - ID_BASE;
    idx = DATE_LEN - 1 - int'(k[2:0]);
    if (a >= ID_BASE && k < ADDR_W'(DATE_LEN)) return DATE_TXT[8*idx +: 8];
    else if (a == ID_MODEL) return MODEL_BYTE;
    else if (a == ID_MODEL + 1'b1) return SUBMODEL_BYTE;
    else return 8'h00;
  endfunction
endpackage

// File: rtl/lmd_cfg_regs.sv
module lmd_cfg_regs
  import lmd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ROM_LIM_RST  = 20'hC7FFF,
  parameter logic [ADDR_W:0]   RAM_SIZE_RST = 21'h100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [ADDR_W:0]   cfg_data_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] rom_lim_o,
  output logic [ADDR_W:0]   ram_size_o,
  output logic              hide_fb_o
);
  logic load;
  assign load = cfg_we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_lim_o  <= ROM_LIM_RST;
      ram_size_o <= RAM_SIZE_RST;
      hide_fb_o  <= 1'b0;
    end else if (load) begin
      case (cfg_sel_i)
        2'd0:    rom_lim_o  <= cfg_data_i[ADDR_W-1:0];
        2'd1:    ram_size_o <= cfg_data_i;
        2'd2:    hide_fb_o  <= cfg_data_i[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lmd_region_decode.sv
module lmd_region_decode
  import lmd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] rom_lim_i,
  input  logic [ADDR_W:0]   ram_size_i,
  input  logic              hide_fb_i,
  output tgt_e              tgt_o,
  output logic [ADDR_W-1:0] off_o,
  output logic              halt_o,
  output logic              warn_o
);
  logic in_vid, in_rom, in_gap, in_id, past_ram;

  assign in_vid   = (addr_i >= VID_BASE) && (addr_i <= VID_TOP);
  assign in_rom   = (addr_i >= ROM_BASE) && (addr_i <= rom_lim_i);
  assign in_gap   = (addr_i >= ROM_BASE) && (addr_i > rom_lim_i) && (addr_i < GAP_END);
  assign in_id    = (addr_i >= ID_BASE);
  assign past_ram = ({1'b0, addr_i} >= ram_size_i);

  always_comb begin
    tgt_o  = TGT_RAM;
    off_o  = addr_i;
    halt_o = 1'b0;
    warn_o = 1'b0;
    if (hide_fb_i && in_vid) begin
      tgt_o = TGT_NONE;
      off_o = '0;
    end else if (in_rom) begin
      tgt_o = TGT_ROM;
      off_o = addr_i - ROM_BASE;
    end else if (in_gap) begin
      off_o  = '0;
      warn_o = 1'b1;
    end else if (in_vid) begin
      tgt_o = TGT_VID;
      off_o = addr_i - VID_BASE;
    end else if (in_id) begin
      tgt_o = TGT_CONST;
      off_o = addr_i - ID_BASE;
    end else if (past_ram) begin
      off_o  = '0;
      halt_o = 1'b1;
    end
  end
endmodule

// File: rtl/lmd_const_lanes.sv
module lmd_const_lanes
  import lmd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [3:0] n_used;
  always_comb begin
    case (size_i)
      2'd0:    n_used = 4'd1;
      2'd1:    n_used = 4'd2;
      default: n_used = 4'(NBYTES);
    endcase
  end

  for (genvar ln = 0; ln < NBYTES; ln++) begin : g_lane
    logic [ADDR_W:0] lane_addr;
    logic            active;
    assign lane_addr = {1'b0, addr_i} + (ADDR_W+1)'(ln);
    assign active    = rd_en_i && (4'(ln) < n_used) && !lane_addr[ADDR_W];
    assign rdata_o[8*ln +: 8] = active ? ident_byte(lane_addr[ADDR_W-1:0]) : 8'h00;
  end
endmodule

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder
  import lmd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ROM_LIM_RST  = 20'hC7FFF,
  parameter logic [ADDR_W:0]   RAM_SIZE_RST = 21'h100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [ADDR_W:0]   cfg_data_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [TGT_W-1:0]  rsp_tgt_o,
  output logic [ADDR_W-1:0] rsp_off_o,
  output logic              rsp_wen_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_halt_o,
  output logic              rsp_warn_o
);
  logic [ADDR_W-1:0] rom_lim;
  logic [ADDR_W:0]   ram_size;
  logic              hide_fb;
  tgt_e              dec_tgt;
  logic [ADDR_W-1:0] dec_off;
  logic              dec_halt, dec_warn;
  logic [DATA_W-1:0] lane_data;
  logic              const_rd, commit;

  lmd_cfg_regs #(
    .ROM_LIM_RST (ROM_LIM_RST),
    .RAM_SIZE_RST(RAM_SIZE_RST)
  ) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_we_i  (cfg_we_i),
    .cfg_sel_i (cfg_sel_i),
    .cfg_data_i(cfg_data_i),
    .busy_i    (req_valid_i),
    .rom_lim_o (rom_lim),
    .ram_size_o(ram_size),
    .hide_fb_o (hide_fb)
  );

  lmd_region_decode i_dec (
    .addr_i    (req_addr_i),
    .rom_lim_i (rom_lim),
    .ram_size_i(ram_size),
    .hide_fb_i (hide_fb),
    .tgt_o     (dec_tgt),
    .off_o     (dec_off),
    .halt_o    (dec_halt),
    .warn_o    (dec_warn)
  );

  assign const_rd = !req_we_i && (dec_tgt == TGT_CONST);

  lmd_const_lanes i_lanes (
    .addr_i (req_addr_i),
    .size_i (req_size_i),
    .rd_en_i(const_rd),
    .rdata_o(lane_data)
  );

  assign commit = req_we_i && (dec_tgt != TGT_NONE) && (dec_tgt != TGT_CONST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_tgt_o   <= '0;
      rsp_off_o   <= '0;
      rsp_wen_o   <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_halt_o  <= 1'b0;
      rsp_warn_o  <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_tgt_o   <= req_valid_i ? dec_tgt : TGT_NONE;
      rsp_off_o   <= req_valid_i ? dec_off : '0;
      rsp_wen_o   <= req_valid_i && commit;
      rsp_rdata_o <= req_valid_i ? lane_data : '0;
      rsp_halt_o  <= req_valid_i && dec_halt;
      rsp_warn_o  <= req_valid_i && dec_warn;
    end
  end
endmodule

// File: rtl/lmd_checker.sv
module lmd_checker
  import lmd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              rsp_valid_o,
  input logic [TGT_W-1:0]  rsp_tgt_o,
  input logic [ADDR_W-1:0] rsp_off_o,
  input logic              rsp_wen_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              rsp_halt_o,
  input logic              rsp_warn_o
);
  logic started;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started <= 1'b0;
    else         started <= 1'b1;
  end

  // R12
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |-> rsp_valid_o == $past(req_valid_i));

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_tgt_o == '0 && rsp_off_o == '0 && !rsp_wen_o &&
                      rsp_rdata_o == '0 && !rsp_halt_o && !rsp_warn_o));

  // R6
  halt_to_ram0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_halt_o |-> (rsp_tgt_o == TGT_RAM && rsp_off_o == '0 && !rsp_warn_o));

  // R2
  gap_to_ram0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_warn_o |-> (rsp_tgt_o == TGT_RAM && rsp_off_o == '0));

  // R8
  hidden_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_tgt_o == TGT_NONE) |-> (rsp_rdata_o == '0 && !rsp_wen_o));

  // R10
  const_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_tgt_o == TGT_CONST) |-> !rsp_wen_o);

  // R3
  vid_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_tgt_o == TGT_VID) |-> (rsp_off_o <= VID_TOP - VID_BASE));
endmodule

bind legacy_mem_decoder lmd_checker i_lmd_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_tgt_o  (rsp_tgt_o),
  .rsp_off_o  (rsp_off_o),
  .rsp_wen_o  (rsp_wen_o),
  .rsp_rdata_o(rsp_rdata_o),
  .rsp_halt_o (rsp_halt_o),
  .rsp_warn_o (rsp_warn_o)
);

// File: tb/test_legacy_mem_decoder.sv
module test_legacy_mem_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [20:0] cfg_data = '0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [1:0]  req_size = '0;
  logic [19:0] req_addr = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_tgt;
  logic [19:0] rsp_off;
  logic        rsp_wen;
  logic [31:0] rsp_rdata;
  logic        rsp_halt;
  logic        rsp_warn;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  legacy_mem_decoder #(
    .ROM_LIM_RST (20'hC7FFF),
    .RAM_SIZE_RST(21'h090000)
  ) i_legacy_mem_decoder (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_size_i(req_size), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_tgt_o(rsp_tgt), .rsp_off_o(rsp_off), .rsp_wen_o(rsp_wen),
    .rsp_rdata_o(rsp_rdata), .rsp_halt_o(rsp_halt), .rsp_warn_o(rsp_warn)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [19:0] addr;
    logic [2:0]  tgt;
    logic [19:0] off;
    logic        halt;
    logic        warn;
    logic        wen;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 20'hC0000, 3'd1, 20'h00000, 1'b0, 1'b0, 1'b0, 32'h0},        // R1
    '{1'b0, 2'd2, 20'hC7FFF, 3'd1, 20'h07FFF, 1'b0, 1'b0, 1'b0, 32'h0},        // R1
    '{1'b0, 2'd0, 20'hC8000, 3'd3, 20'h00000, 1'b0, 1'b1, 1'b0, 32'h0},        // R2
    '{1'b0, 2'd1, 20'hCFFFF, 3'd3, 20'h00000, 1'b0, 1'b1, 1'b0, 32'h0},        // R2
    '{1'b0, 2'd0, 20'hA0000, 3'd2, 20'h00000, 1'b0, 1'b0, 1'b0, 32'h0},        // R3
    '{1'b0, 2'd1, 20'hBFFFF, 3'd2, 20'h1FFFF, 1'b0, 1'b0, 1'b0, 32'h0},        // R3
    '{1'b0, 2'd2, 20'hFFFF5, 3'd4, 20'h00000, 1'b0, 1'b0, 1'b0, 32'h312F3830}, // R4 R5
    '{1'b0, 2'd2, 20'hFFFFC, 3'd4, 20'h00007, 1'b0, 1'b0, 1'b0, 32'h00FC0039}, // R4 R5
    '{1'b0, 2'd1, 20'hFFFF9, 3'd4, 20'h00004, 1'b0, 1'b0, 1'b0, 32'h00002F34}, // R5
    '{1'b0, 2'd0, 20'hFFFFE, 3'd4, 20'h00009, 1'b0, 1'b0, 1'b0, 32'h000000FC}, // R4
    '{1'b0, 2'd3, 20'hFFFFF, 3'd4, 20'h0000A, 1'b0, 1'b0, 1'b0, 32'h00000000}, // R4 R5
    '{1'b0, 2'd0, 20'hD0000, 3'd3, 20'h00000, 1'b1, 1'b0, 1'b0, 32'h0},        // R6
    '{1'b0, 2'd0, 20'h90000, 3'd3, 20'h00000, 1'b1, 1'b0, 1'b0, 32'h0},        // R6
    '{1'b0, 2'd0, 20'h8FFFF, 3'd3, 20'h8FFFF, 1'b0, 1'b0, 1'b0, 32'h0},        // R7
    '{1'b0, 2'd1, 20'h12345, 3'd3, 20'h12345, 1'b0, 1'b0, 1'b0, 32'h0},        // R7
    '{1'b1, 2'd1, 20'hA0010, 3'd2, 20'h00010, 1'b0, 1'b0, 1'b1, 32'h0},        // R10
    '{1'b1, 2'd0, 20'hFFFFE, 3'd4, 20'h00009, 1'b0, 1'b0, 1'b0, 32'h0},        // R10
    '{1'b1, 2'd2, 20'hC8000, 3'd3, 20'h00000, 1'b0, 1'b1, 1'b1, 32'h0},        // R10 R2
    '{1'b1, 2'd0, 20'h00040, 3'd3, 20'h00040, 1'b0, 1'b0, 1'b1, 32'h0},        // R10
    '{1'b0, 2'd1, 20'hFFFFB, 3'd4, 20'h00006, 1'b0, 1'b0, 1'b0, 32'h00003939}  // R5
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic we, input logic [1:0] sz, input logic [19:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_size = sz; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic [2:0] tgt, input logic [19:0] off,
                            input logic halt, input logic warn, input logic wen, input logic [31:0] rd);
    logic [63:0] act, exp;
    act = {rsp_valid, rsp_tgt, rsp_off, rsp_halt, rsp_warn, rsp_wen, rsp_rdata};
    exp = {1'b1, tgt, off, halt, warn, wen, rd};
    check(act == exp, req, act, exp);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [20:0] d, input bit with_req);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    if (with_req) begin req_valid = 1'b1; req_we = 1'b0; req_size = 2'd0; req_addr = 20'hC8000; end
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check({rsp_valid, rsp_tgt, rsp_off, rsp_wen, rsp_rdata, rsp_halt, rsp_warn} == '0, "R12 reset",
          {rsp_valid, rsp_tgt, rsp_off, rsp_halt, rsp_warn}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].we, VECS[i].sz, VECS[i].addr);
      expect_rsp($sformatf("vector %0d addr %h", i, VECS[i].addr), VECS[i].tgt, VECS[i].off,
                 VECS[i].halt, VECS[i].warn, VECS[i].wen, VECS[i].rd);
    end

    // R12 response drops after an idle cycle
    @(negedge clk);
    check(rsp_valid == 1'b0 && rsp_tgt == '0 && rsp_off == '0, "R12 idle", {rsp_valid, rsp_tgt, rsp_off}, 64'h0);

    // R8 frame buffer hidden
    cfg_write(2'd2, 21'd1, 1'b0);
    send(1'b0, 2'd2, 20'hA1234);
    expect_rsp("R8 hidden read", 3'd0, 20'h0, 1'b0, 1'b0, 1'b0, 32'h0);
    send(1'b1, 2'd1, 20'hB0000);
    expect_rsp("R8 hidden write", 3'd0, 20'h0, 1'b0, 1'b0, 1'b0, 32'h0);
    send(1'b0, 2'd0, 20'hC0000);
    expect_rsp("R8 rom unaffected", 3'd1, 20'h0, 1'b0, 1'b0, 1'b0, 32'h0);
    cfg_write(2'd2, 21'd0, 1'b0);
    send(1'b0, 2'd0, 20'hA1234);
    expect_rsp("R8 hiding off again", 3'd2, 20'h01234, 1'b0, 1'b0, 1'b0, 32'h0);

    // R11 config during request ignored
    cfg_write(2'd0, 21'h0CFFFF, 1'b1);
    expect_rsp("R11 busy cycle", 3'd3, 20'h0, 1'b0, 1'b1, 1'b0, 32'h0);
    send(1'b0, 2'd0, 20'hC8000);
    expect_rsp("R11 busy write ignored", 3'd3, 20'h0, 1'b0, 1'b1, 1'b0, 32'h0);
    cfg_write(2'd0, 21'h0CFFFF, 1'b0);
    send(1'b0, 2'd0, 20'hC8000);
    expect_rsp("R11 limit loaded", 3'd1, 20'h08000, 1'b0, 1'b0, 1'b0, 32'h0);
    send(1'b0, 2'd1, 20'hCFFFF);
    expect_rsp("R1 top of raised limit", 3'd1, 20'h0FFFF, 1'b0, 1'b0, 1'b0, 32'h0);

    // R9 priority with a small RAM
    cfg_write(2'd1, 21'h010000, 1'b0);
    send(1'b0, 2'd0, 20'h20000);
    expect_rsp("R6 small ram halt", 3'd3, 20'h0, 1'b1, 1'b0, 1'b0, 32'h0);
    send(1'b0, 2'd0, 20'h0FFFF);
    expect_rsp("R7 last ram byte", 3'd3, 20'h0FFFF, 1'b0, 1'b0, 1'b0, 32'h0);
    send(1'b0, 2'd0, 20'hC0010);
    expect_rsp("R9 rom over range", 3'd1, 20'h00010, 1'b0, 1'b0, 1'b0, 32'h0);
    send(1'b0, 2'd0, 20'hB0000);
    expect_rsp("R9 video over range", 3'd2, 20'h10000, 1'b0, 1'b0, 1'b0, 32'h0);
    send(1'b0, 2'd0, 20'hFFFFE);
    expect_rsp("R9 const over range", 3'd4, 20'h00009, 1'b0, 1'b0, 1'b0, 32'h000000FC);
    cfg_write(2'd0, 21'h0C7FFF, 1'b0);
    send(1'b0, 2'd0, 20'hCFFFF);
    expect_rsp("R9 gap over range", 3'd3, 20'h0, 1'b0, 1'b1, 1'b0, 32'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule